// File: doc/BRIEF.md
# Display Data Channel Bus Slave with Auto-Incrementing Pointer

This block is the monitor side of a two-wire display data channel. It watches the serial clock and data lines, answers only the fixed monitor address, and moves bytes between the bus and a byte-wide local store through an internal pointer. The host is always the bus master and decides the direction of each transfer. The block never drives a line high. It only pulls SCL or SDA low through its two drive-enable outputs, and the board supplies the wired-AND with pull-ups.

In a write transfer, the first data byte sets the pointer. Each later byte is offered on a valid/ready write stream at the pointer address. In a read transfer, the block asks for the byte at the pointer on a valid/ready request stream and then shifts it out MSB first. Back-pressure reaches the bus as clock stretching. While a stream is valid and not ready, SCL is held low. Address and data stay stable until the handshake completes. Single-byte and burst transfers both work, because the pointer advances by one after each completed byte. Repeated START conditions leave the pointer untouched.

Top module: `disp_i2c_slave`

## Requirements
- R1: Out of reset, `scl_oe`, `sda_oe`, `wr_valid` and `rd_valid` are all 0.
- R2: Address byte A0h (7-bit address 50h, direction bit 0 = write) and A1h (direction bit 1 = read) are acknowledged by driving SDA low for the ninth clock. Any other address gets no acknowledge. After such an address, no stream request is raised and no later byte is acknowledged until the next START.
- R3: In a write transfer, the first data byte after the address loads the pointer with its low `PTR_W` bits. That byte is acknowledged and does not appear on the write stream.
- R4: Each later write byte appears once on the write stream with `wr_addr` equal to the pointer. The pointer then advances by one, and the byte is acknowledged.
- R5: While `wr_valid` is high and `wr_ready` is low, SCL is held low and `wr_addr`/`wr_data` stay stable. The acknowledge is given only after the handshake.
- R6: In a read transfer, `rd_valid` is raised with `rd_addr` equal to the pointer. SCL is held low until `rd_ready`. The byte sampled from `rd_data` is sent MSB first.
- R7: After a master ACK, the pointer advances by one and the next byte is requested. After a master NACK, the pointer is unchanged and SDA is no longer driven.
- R8: A repeated START keeps the pointer value from the earlier transfer.
- R9: The pointer wraps from 2^PTR_W-1 to 0.
- R10: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| wr_valid | output | 1 | Write stream: byte available |
| wr_ready | input | 1 | Write stream: local side accepts |
| wr_addr | output | PTR_W | Write stream: buffer location |
| wr_data | output | 8 | Write stream: byte |
| rd_valid | output | 1 | Read request: byte wanted |
| rd_ready | input | 1 | Read request: `rd_data` is valid now |
| rd_addr | output | PTR_W | Read request: buffer location |
| rd_data | input | 8 | Byte supplied by the local side |

## Verification
The bench builds the block with `PTR_W` = 4 and `SYNC_STAGES` = 3. The 4-bit pointer lets a few bytes carry it across the wrap from 15 to 0. It also shows that a loaded pointer byte such as FEh keeps only its low bits. The deeper synchronizer lengthens the delay between a pin edge and the block's reaction, which tests the stretch and drive timing against a master that holds each clock phase for a fixed number of cycles.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;
  localparam logic [6:0] DISP_ADDR = 7'h50;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_RX,
    ST_WR_WAIT,
    ST_RD_WAIT,
    ST_REL,
    ST_TX,
    ST_RACK
  } st_e;
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain;
  logic              prev;

  // Reset to the idle (released) level so no edge appears after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], d_i};
      prev  <= chain[STAGES-1];
    end
  end

  assign q_o    = chain[STAGES-1];
  assign rise_o = chain[STAGES-1] & ~prev;
  assign fall_o = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/i2cs_ptr.sv
module i2cs_ptr #(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             inc,
  output logic [PTR_W-1:0] ptr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr_o <= '0;
    else if (load) ptr_o <= load_val;
    else if (inc)  ptr_o <= ptr_o + PTR_W'(1);
  end
endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
  import i2cs_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_q,
  input  logic              start_evt,
  input  logic              stop_evt,
  output logic              ptr_load,
  output logic [PTR_W-1:0]  ptr_val,
  output logic              ptr_inc,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  input  logic [BYTE_W-1:0] rd_data
);
  st_e               state, rel_nxt;
  logic [BYTE_W-1:0] sh;
  logic [3:0]        cnt;
  logic              rnw, first, mack;
  logic              quiet, byte_done;

  assign quiet     = !start_evt && !stop_evt;
  assign byte_done = scl_fall && (cnt == 4'd8);

  assign ptr_load = quiet && (state == ST_RX) && byte_done && first;
  assign ptr_val  = sh[PTR_W-1:0];
  assign ptr_inc  = (state == ST_WR_WAIT && wr_ready) ||
                    (quiet && state == ST_RACK && scl_fall && mack);

  assign wr_valid = (state == ST_WR_WAIT);
  assign rd_valid = (state == ST_RD_WAIT);
  assign wr_data  = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      rel_nxt <= ST_IDLE;
      sh      <= '0;
      cnt     <= '0;
      rnw     <= 1'b0;
      first   <= 1'b0;
      mack    <= 1'b0;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (start_evt) begin
      state  <= ST_ADDR;
      cnt    <= '0;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_evt) begin
      state  <= ST_IDLE;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: ;
        ST_ADDR: begin
          if (scl_rise && cnt < 4'd8) begin
            sh  <= {sh[BYTE_W-2:0], sda_q};
            cnt <= cnt + 4'd1;
          end else if (byte_done) begin
            if (sh[7:1] == DISP_ADDR) begin
              rnw    <= sh[0];
              first  <= ~sh[0];
              sda_oe <= 1'b1;
              state  <= ST_ACK;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            if (rnw) begin
              scl_oe <= 1'b1;
              state  <= ST_RD_WAIT;
            end else begin
              state <= ST_RX;
            end
          end
        end
        ST_RX: begin
          if (scl_rise && cnt < 4'd8) begin
            sh  <= {sh[BYTE_W-2:0], sda_q};
            cnt <= cnt + 4'd1;
          end else if (byte_done) begin
            if (first) begin
              first  <= 1'b0;
              sda_oe <= 1'b1;
              state  <= ST_ACK;
            end else begin
              scl_oe <= 1'b1;
              state  <= ST_WR_WAIT;
            end
          end
        end
        ST_WR_WAIT: begin
          if (wr_ready) begin
            sda_oe  <= 1'b1;
            rel_nxt <= ST_ACK;
            state   <= ST_REL;
          end
        end
        ST_RD_WAIT: begin
          if (rd_ready) begin
            sh      <= rd_data;
            sda_oe  <= ~rd_data[BYTE_W-1];
            cnt     <= '0;
            rel_nxt <= ST_TX;
            state   <= ST_REL;
          end
        end
        ST_REL: begin
          // SDA settled one cycle earlier; now let SCL rise.
          scl_oe <= 1'b0;
          state  <= rel_nxt;
        end
        ST_TX: begin
          if (scl_rise && cnt < 4'd8) begin
            cnt <= cnt + 4'd1;
          end else if (byte_done) begin
            sda_oe <= 1'b0;
            state  <= ST_RACK;
          end else if (scl_fall && cnt != 4'd0) begin
            sh     <= {sh[BYTE_W-2:0], 1'b0};
            sda_oe <= ~sh[BYTE_W-2];
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack <= ~sda_q;
          end else if (scl_fall) begin
            if (mack) begin
              scl_oe <= 1'b1;
              state  <= ST_RD_WAIT;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/disp_i2c_slave.sv
module disp_i2c_slave
  import i2cs_pkg::*;
#(
  parameter int PTR_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [PTR_W-1:0]  wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [PTR_W-1:0]  rd_addr,
  input  logic [BYTE_W-1:0] rd_data
);
  localparam int NLINES = 2;
  localparam int SCL    = 0;
  localparam int SDA    = 1;

  logic [NLINES-1:0] raw, lq, lrise, lfall;
  logic              start_evt, stop_evt;
  logic              ptr_load, ptr_inc;
  logic [PTR_W-1:0]  ptr_val, ptr;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    (raw[g]),
      .q_o    (lq[g]),
      .rise_o (lrise[g]),
      .fall_o (lfall[g])
    );
  end

  // SDA edge while SCL was already high and stays high.
  assign start_evt = lfall[SDA] && lq[SCL] && !lrise[SCL];
  assign stop_evt  = lrise[SDA] && lq[SCL] && !lrise[SCL];

  i2cs_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ptr_load),
    .load_val (ptr_val),
    .inc      (ptr_inc),
    .ptr_o    (ptr)
  );

  i2cs_ctrl #(.PTR_W(PTR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (lrise[SCL]),
    .scl_fall  (lfall[SCL]),
    .sda_q     (lq[SDA]),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .ptr_load  (ptr_load),
    .ptr_val   (ptr_val),
    .ptr_inc   (ptr_inc),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_data   (wr_data),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data)
  );

  assign wr_addr = ptr;
  assign rd_addr = ptr;
endmodule

// File: rtl/i2cs_checks.sv
module i2cs_checks #(
  parameter int PTR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_i,
  input logic             scl_oe,
  input logic             sda_oe,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [PTR_W-1:0] wr_addr,
  input logic [7:0]       wr_data,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [PTR_W-1:0] rd_addr
);
  // R4
  wr_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready |=> !wr_valid);

  // R5
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  // R5
  wr_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> scl_oe);

  // R6
  rd_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> scl_oe);

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  // R10
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_i));
endmodule

bind disp_i2c_slave i2cs_checks #(.PTR_W(PTR_W)) u_checks (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_i    (scl_i),
  .scl_oe   (scl_oe),
  .sda_oe   (sda_oe),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .rd_addr  (rd_addr)
);

// File: tb/tb_disp_i2c_slave.sv
module tb_disp_i2c_slave;
  localparam int CLK_NS = 10;
  localparam int PW     = 4;
  localparam int Q      = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_line, sda_line;
  logic scl_oe, sda_oe;
  logic wr_valid, rd_valid;
  logic wr_ready = 1'b0, rd_ready = 1'b0;
  logic [PW-1:0] wr_addr, rd_addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data = 8'h00;

  assign scl_line = scl_m & ~scl_oe;
  assign sda_line = sda_m & ~sda_oe;

  disp_i2c_slave #(.PTR_W(PW), .SYNC_STAGES(3)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  typedef struct packed { logic [PW-1:0] a; logic [7:0] d; } witem_t;
  witem_t wq[$];
  logic [7:0] mem [16];
  int lat = 0;
  int tests = 0, fails = 0, wr_hs = 0, rd_hs = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qwait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up();
    scl_m = 1'b1;
    while (scl_line !== 1'b1) @(negedge clk);
    qwait(Q);
  endtask

  task automatic m_start();
    sda_m = 1'b1; qwait(Q);
    scl_up();
    sda_m = 1'b0; qwait(Q);
    scl_m = 1'b0; qwait(Q);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; qwait(Q);
    scl_up();
    sda_m = 1'b1; qwait(Q);
  endtask

  task automatic wbit(input bit b);
    sda_m = b; qwait(Q);
    scl_up(); qwait(Q);
    scl_m = 1'b0; qwait(Q);
  endtask

  task automatic rbit(output bit b, output bit st);
    sda_m = 1'b1; qwait(Q);
    scl_up();
    b = sda_line; qwait(Q);
    st = (sda_line == b);
    scl_m = 1'b0; qwait(Q);
  endtask

  task automatic wbyte(input logic [7:0] v, output bit ack);
    bit b, s;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(b, s);
    ack = !b;
  endtask

  task automatic rbyte(output logic [7:0] v, input bit ack, output bit st_all);
    bit b, s;
    st_all = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      rbit(b, s);
      v[i] = b;
      st_all &= s;
    end
    wbit(!ack);
  endtask

  // driver side of the scoreboard
  task automatic wr_push(input logic [PW-1:0] a, input logic [7:0] d);
    wq.push_back('{a: a, d: d});
  endtask

  // local controller model and scoreboard monitor
  initial begin
    witem_t e;
    forever begin
      @(negedge clk);
      if (wr_valid) begin
        repeat (lat) @(negedge clk);
        check(scl_oe && wr_valid, "R5 stretch while write pending", scl_oe, 1);
        if (wq.size() == 0) begin
          check(1'b0, "R4 unexpected write", {wr_addr, wr_data}, 0);
        end else begin
          e = wq.pop_front();
          check(wr_addr == e.a && wr_data == e.d, "R4 write item",
                {wr_addr, wr_data}, {e.a, e.d});
        end
        mem[wr_addr] = wr_data;
        wr_hs++;
        wr_ready = 1'b1;
        @(negedge clk);
        wr_ready = 1'b0;
      end else if (rd_valid) begin
        repeat (lat) @(negedge clk);
        check(scl_oe && rd_valid, "R6 stretch while read pending", scl_oe, 1);
        rd_data  = mem[rd_addr];
        rd_hs++;
        rd_ready = 1'b1;
        @(negedge clk);
        rd_ready = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit ack, st;
    logic [7:0] v;
    int hs0, rs0;
    for (int i = 0; i < 16; i++) mem[i] = 8'h40 + 8'(i);

    qwait(5);
    check(!scl_oe && !sda_oe && !wr_valid && !rd_valid, "R1 reset outputs",
          {scl_oe, sda_oe, wr_valid, rd_valid}, 0);
    rst_n = 1'b1;
    qwait(5);

    // write burst with stretching, then repeated START into a read
    lat = 3;
    m_start();
    wbyte(8'hA0, ack); check(ack, "R2 write address ack", ack, 1);
    wbyte(8'hF5, ack); check(ack, "R3 pointer byte ack", ack, 1);
    check(wr_hs == 0, "R3 pointer byte not streamed", wr_hs, 0);
    wr_push(4'd5, 8'h11); wbyte(8'h11, ack); check(ack, "R4 data ack", ack, 1);
    wr_push(4'd6, 8'h22); wbyte(8'h22, ack); check(ack, "R4 data ack", ack, 1);
    wr_push(4'd7, 8'h33); wbyte(8'h33, ack); check(ack, "R4 data ack", ack, 1);
    check(wq.size() == 0, "R4 all writes seen", wq.size(), 0);
    m_start();
    wbyte(8'hA1, ack); check(ack, "R2 read address ack", ack, 1);
    rbyte(v, 1'b0, st);
    check(v == mem[8], "R8 pointer kept over repeated START", v, mem[8]);
    m_stop();

    // NACK left the pointer unchanged
    m_start();
    wbyte(8'hA1, ack); check(ack, "R2 read address ack", ack, 1);
    rbyte(v, 1'b0, st);
    check(v == mem[8], "R7 no advance after NACK", v, mem[8]);
    m_stop();

    // set pointer then burst read
    lat = 1;
    m_start();
    wbyte(8'hA0, ack); check(ack, "R2 write address ack", ack, 1);
    wbyte(8'h06, ack); check(ack, "R3 pointer byte ack", ack, 1);
    m_start();
    wbyte(8'hA1, ack); check(ack, "R2 read address ack", ack, 1);
    rbyte(v, 1'b1, st); check(v == 8'h22, "R6 first read byte", v, 8'h22);
    check(st, "R10 SDA steady while SCL high", st, 1);
    rbyte(v, 1'b1, st); check(v == 8'h33, "R7 advance after ACK", v, 8'h33);
    check(st, "R10 SDA steady while SCL high", st, 1);
    rbyte(v, 1'b0, st); check(v == mem[8], "R7 burst third byte", v, mem[8]);
    qwait(3);
    check(!sda_oe && !rd_valid, "R7 released after NACK", {sda_oe, rd_valid}, 0);
    m_stop();

    // foreign addresses
    hs0 = wr_hs; rs0 = rd_hs;
    m_start();
    wbyte(8'hA4, ack); check(!ack, "R2 foreign address no ack", ack, 0);
    wbyte(8'h12, ack); check(!ack, "R2 later byte ignored", ack, 0);
    m_stop();
    m_start();
    wbyte(8'hA3, ack); check(!ack, "R2 foreign read address no ack", ack, 0);
    m_stop();
    check(wr_hs == hs0 && rd_hs == rs0, "R2 no stream activity", wr_hs + rd_hs, hs0 + rs0);

    // pointer wrap, upper pointer bits dropped
    lat = 0;
    m_start();
    wbyte(8'hA0, ack); check(ack, "R2 write address ack", ack, 1);
    wbyte(8'hFE, ack); check(ack, "R3 pointer low bits", ack, 1);
    wr_push(4'd14, 8'hC1); wbyte(8'hC1, ack);
    wr_push(4'd15, 8'hC2); wbyte(8'hC2, ack);
    wr_push(4'd0,  8'hC3); wbyte(8'hC3, ack);
    check(ack && wq.size() == 0, "R9 write wraps to 0", wq.size(), 0);
    m_stop();
    m_start();
    wbyte(8'hA0, ack);
    wbyte(8'h0F, ack);
    m_start();
    wbyte(8'hA1, ack); check(ack, "R2 read address ack", ack, 1);
    rbyte(v, 1'b1, st); check(v == 8'hC2, "R9 read at 15", v, 8'hC2);
    rbyte(v, 1'b0, st); check(v == 8'hC3, "R9 read wraps to 0", v, 8'hC3);
    m_stop();

    qwait(20);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule